// File: doc/BRIEF.md
# Receive Status Priority Encoder

This block sits at the end of a serial receive path and condenses the event flags raised in one cycle into the 3-bit receive status code that a PCIe-style PHY reports to the link layer. The flags arrive from the symbol decoder, from the elastic buffer that adds and removes SKP symbols to absorb clock offset, and from receiver detection. The flags are: data good, SKP added, SKP removed, receiver present, decode error, buffer overflow, buffer underflow, and disparity error.

In any cycle, any mix of flags may be set. A fixed priority resolves them into one code. Errors come first. If two or more error flags are set together, the block reports the decode-error code and does not pick one of the errors by rank. After the errors, receiver-present ranks above SKP added, SKP added ranks above SKP removed, and that ranks above data good.

The status is registered. Several lanes are built side by side from one parameter, and each lane has its own flags and its own 3-bit status field.

Top module: `rx_status_enc`

## Requirements
- R1: Each lane's status is registered, so it shows the result of the flags sampled at the previous rising clock edge. A synchronous active-high reset clears it to 3'b000.
- R2: When exactly one error flag is set, the status is that error's code: decode error 3'b100, overflow 3'b101, underflow 3'b110, disparity error 3'b111.
- R3: When two or more error flags are set in the same cycle, the status is 3'b100. No other flag affects this result.
- R4: When no error flag is set and receiver-present is set, the status is 3'b011, whatever the SKP and data-good flags are.
- R5: When no error flag and no receiver-present flag is set, SKP added gives 3'b001, even if SKP removed is also set.
- R6: When only SKP removed is set among the error, receiver-present and SKP-added flags, the status is 3'b010.
- R7: When data good is the only flag set, or no flag is set, the status is 3'b000.
- R8: Lane k uses only bit k of each flag input and drives only status bits [3k+2:3k]. Lanes do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_ok | input | LANES | Data good, one bit per lane |
| in_skp_add | input | LANES | SKP symbol added by elastic buffer |
| in_skp_del | input | LANES | SKP symbol removed by elastic buffer |
| in_rxdet | input | LANES | Receiver present |
| in_dec_err | input | LANES | Symbol decode error |
| in_ovf | input | LANES | Elastic buffer overflow |
| in_unf | input | LANES | Elastic buffer underflow |
| in_disp | input | LANES | Running disparity error |
| rx_status | output | 3*LANES | Status code per lane, lane k in bits [3k+2:3k] |

## Verification
The hardest cases to reach are cycles in which several error flags coincide with receiver-present and SKP flags. Only a correct collapse to 3'b100 separates the design from one that simply picks the highest-ranked error.

To reach them, the random stimulus sets each flag independently with a high probability, so multi-error cycles appear often on every lane. Directed cycles then walk through every pair of error flags combined with all lower-ranked flags. They also pit receiver-present against both SKP flags and give the two lanes opposite patterns to test independence.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;

    typedef enum logic [2:0] {
        ST_OK      = 3'b000,
        ST_SKP_ADD = 3'b001,
        ST_SKP_DEL = 3'b010,
        ST_RXDET   = 3'b011,
        ST_DEC_ERR = 3'b100,
        ST_OVF     = 3'b101,
        ST_UNF     = 3'b110,
        ST_DISP    = 3'b111
    } rx_status_e;

    localparam int NUM_ERR = 4;
    localparam int ERR_CNT_W = $clog2(NUM_ERR + 1);

    typedef struct packed {
        logic dec_err;
        logic ovf;
        logic unf;
        logic disp;
    } err_flags_t;

    typedef struct packed {
        logic       ok;
        logic       skp_add;
        logic       skp_del;
        logic       rxdet;
        err_flags_t err;
    } rx_events_t;

    function automatic logic [ERR_CNT_W-1:0] count_err(input err_flags_t e);
        logic [NUM_ERR-1:0]   v;
        logic [ERR_CNT_W-1:0] n;
        v = e;
        n = '0;
        for (int i = 0; i < NUM_ERR; i++) begin
            n = n + ERR_CNT_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/rx_err_merge.sv
module rx_err_merge
    import rx_status_pkg::*;
(
    input  err_flags_t err,
    output logic       err_any,
    output rx_status_e err_code
);
    logic [ERR_CNT_W-1:0] n_err;

    always_comb begin
        n_err   = count_err(err);
        err_any = (n_err != '0);
        if (n_err > ERR_CNT_W'(1)) begin
            err_code = ST_DEC_ERR;
        end else if (err.ovf) begin
            err_code = ST_OVF;
        end else if (err.unf) begin
            err_code = ST_UNF;
        end else if (err.disp) begin
            err_code = ST_DISP;
        end else begin
            err_code = ST_DEC_ERR;
        end
    end

    always_comb begin
        if (n_err > ERR_CNT_W'(1)) begin
            assert (err_code == ST_DEC_ERR)
                else $error("AST_COLLAPSE_MULTI failed"); // R3
        end
    end
endmodule

// File: rtl/rx_lane_enc.sv
module rx_lane_enc
    import rx_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_events_t ev,
    output rx_status_e status
);
    logic       err_any;
    rx_status_e err_code;
    rx_status_e next_st;
    logic       armed;

    rx_err_merge u_err (
        .err      (ev.err),
        .err_any  (err_any),
        .err_code (err_code)
    );

    always_comb begin
        if (err_any)          next_st = err_code;
        else if (ev.rxdet)    next_st = ST_RXDET;
        else if (ev.skp_add)  next_st = ST_SKP_ADD;
        else if (ev.skp_del)  next_st = ST_SKP_DEL;
        else                  next_st = ST_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= ST_OK;
            armed  <= 1'b0;
        end else begin
            status <= next_st;
            armed  <= 1'b1;
        end
    end

    AST_MULTI_ERR: assert property (@(posedge clk) disable iff (rst || !armed)
        (count_err($past(ev.err)) > ERR_CNT_W'(1)) |-> (status == ST_DEC_ERR)); // R3

    AST_ERR_CLASS: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(ev.err) != '0) |-> status[2]); // R2

    AST_RXDET_CODE: assert property (@(posedge clk) disable iff (rst || !armed)
        (($past(ev.err) == '0) && $past(ev.rxdet)) |-> (status == ST_RXDET)); // R4

    AST_SKP_ADD_CODE: assert property (@(posedge clk) disable iff (rst || !armed)
        (($past(ev.err) == '0) && !$past(ev.rxdet) && $past(ev.skp_add))
        |-> (status == ST_SKP_ADD)); // R5

    AST_QUIET_OK: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past({ev.skp_add, ev.skp_del, ev.rxdet, ev.err}) == '0) |-> (status == ST_OK)); // R7

    AST_OK_ONLY: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(ev.ok) && !$past(ev.skp_del) && !$past(ev.skp_add) && !$past(ev.rxdet)
         && ($past(ev.err) == '0)) |-> (status == ST_OK)); // R7
endmodule

// File: rtl/rx_status_enc.sv
module rx_status_enc
    import rx_status_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   in_ok,
    input  logic [LANES-1:0]   in_skp_add,
    input  logic [LANES-1:0]   in_skp_del,
    input  logic [LANES-1:0]   in_rxdet,
    input  logic [LANES-1:0]   in_dec_err,
    input  logic [LANES-1:0]   in_ovf,
    input  logic [LANES-1:0]   in_unf,
    input  logic [LANES-1:0]   in_disp,
    output logic [3*LANES-1:0] rx_status
);
    localparam int ST_W = 3;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        rx_events_t ev;
        rx_status_e st;

        always_comb begin
            ev.ok          = in_ok[k];
            ev.skp_add     = in_skp_add[k];
            ev.skp_del     = in_skp_del[k];
            ev.rxdet       = in_rxdet[k];
            ev.err.dec_err = in_dec_err[k];
            ev.err.ovf     = in_ovf[k];
            ev.err.unf     = in_unf[k];
            ev.err.disp    = in_disp[k];
        end

        rx_lane_enc u_lane (
            .clk    (clk),
            .rst    (rst),
            .ev     (ev),
            .status (st)
        );

        assign rx_status[ST_W*k +: ST_W] = st;
    end
endmodule

// File: tb/rx_status_enc_test.sv
module rx_status_enc_test;
    localparam int LANES = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [LANES-1:0]   in_ok = '0, in_skp_add = '0, in_skp_del = '0, in_rxdet = '0;
    logic [LANES-1:0]   in_dec_err = '0, in_ovf = '0, in_unf = '0, in_disp = '0;
    logic [3*LANES-1:0] rx_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_status_enc #(.LANES(LANES)) uut (
        .clk(clk), .rst(rst),
        .in_ok(in_ok), .in_skp_add(in_skp_add), .in_skp_del(in_skp_del),
        .in_rxdet(in_rxdet), .in_dec_err(in_dec_err), .in_ovf(in_ovf),
        .in_unf(in_unf), .in_disp(in_disp), .rx_status(rx_status)
    );

    // flag bits: 0 ok,1 add,2 del,3 rxdet,4 dec,5 ovf,6 unf,7 disp
    function automatic logic [2:0] model(input logic [7:0] f);
        int ne;
        ne = f[4] + f[5] + f[6] + f[7];
        if (ne >= 2)    return 3'b100;   // R3
        if (f[4])       return 3'b100;   // R2
        if (f[5])       return 3'b101;   // R2
        if (f[6])       return 3'b110;   // R2
        if (f[7])       return 3'b111;   // R2
        if (f[3])       return 3'b011;   // R4
        if (f[1])       return 3'b001;   // R5
        if (f[2])       return 3'b010;   // R6
        return 3'b000;                   // R7
    endfunction

    function automatic string tag(input logic [7:0] f);
        int ne;
        ne = f[4] + f[5] + f[6] + f[7];
        if (ne >= 2) return "R3";
        if (ne == 1) return "R2";
        if (f[3])    return "R4";
        if (f[1])    return "R5";
        if (f[2])    return "R6";
        return "R7";
    endfunction

    logic [7:0] cur [LANES];

    task automatic apply_and_check(input logic [7:0] f0, input logic [7:0] f1);
        @(negedge clk);
        cur[0] = f0; cur[1] = f1;
        for (int k = 0; k < LANES; k++) begin
            in_ok[k] = cur[k][0]; in_skp_add[k] = cur[k][1]; in_skp_del[k] = cur[k][2];
            in_rxdet[k] = cur[k][3]; in_dec_err[k] = cur[k][4]; in_ovf[k] = cur[k][5];
            in_unf[k] = cur[k][6]; in_disp[k] = cur[k][7];
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < LANES; k++) begin
            logic [2:0] exp_st;
            exp_st = model(cur[k]);
            checks++;
            if (rx_status[3*k +: 3] !== exp_st) begin
                errors++;
                $display("FAIL %s (R1/R8 lane %0d) flags=%b actual=%b expected=%b",
                         tag(cur[k]), k, cur[k], rx_status[3*k +: 3], exp_st);
            end
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1 reset state, with flags active during reset
        in_dec_err = '1; in_ovf = '1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rx_status !== '0) begin
            errors++;
            $display("FAIL R1 reset actual=%b expected=%b", rx_status, 6'b0);
        end
        @(negedge clk);
        rst = 1'b0;

        // directed: single errors (R2), quiet and ok (R7)
        apply_and_check(8'h00, 8'h01);
        apply_and_check(8'h10, 8'h20);
        apply_and_check(8'h40, 8'h80);
        apply_and_check(8'h1F, 8'h2F);   // one error with all lower flags
        apply_and_check(8'h4F, 8'h8F);
        // R4 over SKP, R5 add over del, R6 del alone, R8 opposite lanes
        apply_and_check(8'h0F, 8'h06);
        apply_and_check(8'h04, 8'h0E);
        apply_and_check(8'h05, 8'h03);
        // R3: every pair of errors with all lower flags set
        for (int a = 4; a < 8; a++)
            for (int b = a + 1; b < 8; b++)
                apply_and_check(8'h0F | (8'h1 << a) | (8'h1 << b), 8'h01);
        apply_and_check(8'hE0, 8'hF0);
        apply_and_check(8'hA0, 8'h60);
        apply_and_check(8'h00, 8'hFF);

        // random: each flag with probability 3/8
        for (int n = 0; n < 600; n++) begin
            logic [7:0] r0, r1;
            for (int i = 0; i < 8; i++) begin
                r0[i] = ($urandom % 8) < 3;
                r1[i] = ($urandom % 8) < 3;
            end
            apply_and_check(r0, r1);
        end

        // R1 reset mid-run clears status
        @(negedge clk);
        rst = 1'b1;
        in_disp = '1;
        @(posedge clk);
        #1;
        checks++;
        if (rx_status !== '0) begin
            errors++;
            $display("FAIL R1 mid-run reset actual=%b expected=%b", rx_status, 6'b0);
        end
        @(negedge clk);
        rst = 1'b0;
        apply_and_check(8'h80, 8'h02);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule